// File: doc/BRIEF.md
# DDR Power-Up Command Sequencer

This block takes a DDR SDRAM from power-up to normal operation. After a single start pulse it drives a fixed series of commands toward the memory. The series is: precharge of all banks, a load of the extended mode register that turns the DLL on, a load of the mode register that also resets the DLL, and a wait for the DLL to lock. A second precharge-all and two auto-refresh commands follow. A final mode register load then repeats the same fields with the DLL reset bit cleared. Each command lasts one clock cycle. A parameterized minimum spacing follows each command, and NOP is driven in every cycle in between.

Once the final mode register load and its spacing are over, the block raises its done flag. From that point it issues an auto-refresh command at a fixed interval, and never before. The burst length code, burst ordering, CAS latency code and the spacing values are parameters. The command output is the standard row-strobe/column-strobe/write-enable triple. The bank and address outputs carry the mode register contents during mode loads.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted, and until a start pulse is sampled, the command output is NOP (ras/cas/we = 3'b111) and done is low.
- R2: In the cycle after start is sampled in the idle state, a precharge-all is driven: command 3'b010 with address bit 10 set.
- R3: T_RP cycles after the first precharge, a mode load (3'b000) is driven to bank 2'b01 with address 0, which means the DLL is enabled and drive strength is full.
- R4: T_MRD cycles later, a mode load to bank 2'b00 is driven with address 0x163. This encodes DLL reset at bit 8, CAS latency 2.5 (code 3'b110) in bits 6:4, sequential bursts (bit 3 clear) and burst length 8 (code 3'b011) in bits 2:0.
- R5: The next command comes T_DLL cycles after the DLL-reset load, and T_DLL is at least 200.
- R6: That command is a precharge-all. T_RP cycles later an auto-refresh (3'b001) follows, and a second auto-refresh follows T_RFC cycles after the first.
- R7: T_RFC cycles after the second refresh, a mode load to bank 2'b00 is driven with address 0x063: the same fields with the DLL reset bit cleared.
- R8: Every command lasts exactly one cycle, and NOP is driven in all other cycles of the sequence.
- R9: Done rises T_MRD cycles after the final mode load and then stays high until reset.
- R10: Periodic auto-refresh happens only while done is high. The first one falls in the T_REFI-th cycle with done high, and later ones follow every T_REFI cycles.
- R11: A start pulse is ignored while the sequence is running or after done has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin the power-up series |
| cmd_o | output | 3 | ras_n, cas_n, we_n command triple |
| bank_o | output | 2 | Bank address; selects the mode register during loads |
| addr_o | output | 13 | Address bus; mode fields and the precharge-all bit |
| done_o | output | 1 | Memory ready; periodic refresh is active |

## Verification
The scoreboard holds every expected command together with its exact cycle, so a wrong opcode, bank, address or spacing, or any extra command, shows up as a mismatch. In one run, start pulses are sent during the DLL wait and after done has risen, where a restart would inject an unexpected precharge. That run also continues through several refresh intervals, which separates a correct first-refresh offset from an off-by-one offset. A second run after reset uses a different start time, which shows that all spacing is measured from the start pulse and not from reset.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_GAP,
    ST_READY
  } seq_state_e;

  localparam int NUM_STEPS = 7;
  localparam int STEP_W    = 3;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/init_step_rom.sv
module init_step_rom
  import ddr_init_pkg::*;
#(
  parameter int AW         = 13,
  parameter int BAW        = 2,
  parameter int CW         = 8,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 10,
  parameter int T_DLL      = 200,
  parameter int BL_CODE    = 3,
  parameter int CAS_CODE   = 6,
  parameter bit INTERLEAVE = 1'b0,
  parameter bit HALF_DRIVE = 1'b0
) (
  input  logic [STEP_W-1:0] step_i,
  output ddr_cmd_e          cmd_o,
  output logic [BAW-1:0]    bank_o,
  output logic [AW-1:0]     addr_o,
  output logic [CW-1:0]     gap_o
);
  // Mode register image: burst length [2:0], ordering [3], CAS [6:4], DLL reset [8]
  localparam logic [AW-1:0] MR_BASE =
      AW'(BL_CODE & 7) | (AW'(INTERLEAVE) << 3) | (AW'(CAS_CODE & 7) << 4);
  localparam logic [AW-1:0] MR_DLLRST = MR_BASE | (AW'(1) << 8);
  // Extended image: bit 0 = 0 keeps DLL on, bit 1 selects reduced drive
  localparam logic [AW-1:0] EMR_VAL   = AW'(HALF_DRIVE) << 1;
  localparam logic [AW-1:0] PRE_ALL   = AW'(1) << 10;

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = '0;
    addr_o = '0;
    gap_o  = CW'(T_MRD);
    unique case (step_i)
      3'd0: begin cmd_o = CMD_PRE; addr_o = PRE_ALL;   gap_o = CW'(T_RP);  end
      3'd1: begin cmd_o = CMD_LMR; bank_o = BAW'(1); addr_o = EMR_VAL; gap_o = CW'(T_MRD); end
      3'd2: begin cmd_o = CMD_LMR; addr_o = MR_DLLRST; gap_o = CW'(T_DLL); end
      3'd3: begin cmd_o = CMD_PRE; addr_o = PRE_ALL;   gap_o = CW'(T_RP);  end
      3'd4: begin cmd_o = CMD_REF;                     gap_o = CW'(T_RFC); end
      3'd5: begin cmd_o = CMD_REF;                     gap_o = CW'(T_RFC); end
      3'd6: begin cmd_o = CMD_LMR; addr_o = MR_BASE;   gap_o = CW'(T_MRD); end
      default: begin cmd_o = CMD_NOP; end
    endcase
  end
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/refresh_ticker.sv
module refresh_ticker #(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic fire_o
);
  localparam int RW = $clog2(T_REFI + 1);
  logic [RW-1:0] cnt_q, cnt_d;

  assign fire_o = en_i && (cnt_q == RW'(T_REFI - 1));

  always_comb begin
    if (!en_i)       cnt_d = '0;
    else if (fire_o) cnt_d = '0;
    else             cnt_d = cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int AW         = 13,
  parameter int BAW        = 2,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter int T_RFC      = 10,
  parameter int T_DLL      = 200,
  parameter int T_REFI     = 780,
  parameter int BL_CODE    = 3,
  parameter int CAS_CODE   = 6,
  parameter bit INTERLEAVE = 1'b0,
  parameter bit HALF_DRIVE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  output logic [2:0]     cmd_o,
  output logic [BAW-1:0] bank_o,
  output logic [AW-1:0]  addr_o,
  output logic           done_o
);
  localparam int GAP_A   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int GAP_B   = (T_RFC > T_DLL) ? T_RFC : T_DLL;
  localparam int GAP_MAX = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int CW      = $clog2(GAP_MAX + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  logic              rst_i_n;
  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  ddr_cmd_e          rom_cmd;
  logic [BAW-1:0]    rom_bank;
  logic [AW-1:0]     rom_addr;
  logic [CW-1:0]     rom_gap;
  logic              gap_last;
  logic              ref_fire;

  seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  init_step_rom #(
    .AW(AW), .BAW(BAW), .CW(CW), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC),
    .T_DLL(T_DLL), .BL_CODE(BL_CODE), .CAS_CODE(CAS_CODE),
    .INTERLEAVE(INTERLEAVE), .HALF_DRIVE(HALF_DRIVE)
  ) u_rom (
    .step_i (step_q),
    .cmd_o  (rom_cmd),
    .bank_o (rom_bank),
    .addr_o (rom_addr),
    .gap_o  (rom_gap)
  );

  gap_timer #(.CW(CW)) u_gap (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load_i     (st_q == ST_ISSUE),
    .load_val_i (rom_gap - CW'(1)),
    .last_o     (gap_last)
  );

  refresh_ticker #(.T_REFI(T_REFI)) u_refi (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .en_i   (st_q == ST_READY),
    .fire_o (ref_fire)
  );

  // Next-state logic; start is only looked at in idle
  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    step_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_ISSUE;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      ST_ISSUE: st_d = ST_GAP;
      ST_GAP: begin
        if (gap_last) begin
          if (step_q == LAST_STEP) begin
            st_d = ST_READY;
          end else begin
            st_d    = ST_ISSUE;
            step_d  = step_q + STEP_W'(1);
            step_en = 1'b1;
          end
        end
      end
      ST_READY: st_d = ST_READY;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
    end else begin
      st_q <= st_d;
      if (step_en) step_q <= step_d;
    end
  end

  // Command decode from registered state
  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = '0;
    addr_o = '0;
    if (st_q == ST_ISSUE) begin
      cmd_o  = rom_cmd;
      bank_o = rom_bank;
      addr_o = rom_addr;
    end else if (ref_fire) begin
      cmd_o = CMD_REF;
    end
  end

  assign done_o = (st_q == ST_READY);
endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
  parameter int AW    = 13,
  parameter int BAW   = 2,
  parameter int T_DLL = 200
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     cmd_o,
  input logic [BAW-1:0] bank_o,
  input logic [AW-1:0]  addr_o,
  input logic           done_o
);
  logic        is_dllrst;
  logic        armed_q;
  logic [15:0] since_q;

  assign is_dllrst = (cmd_o == 3'b000) && (bank_o == '0) && addr_o[8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      since_q <= '0;
    end else begin
      if (is_dllrst) begin
        armed_q <= 1'b1;
        since_q <= '0;
      end else begin
        if (cmd_o != 3'b111) armed_q <= 1'b0;
        if (since_q != 16'hFFFF) since_q <= since_q + 16'd1;
      end
    end
  end

  assert_pre_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'b010) |-> addr_o[10]);

  assert_mr_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 3'b000 && bank_o == '0) |-> (addr_o[6:0] == 7'h63));

  assert_dll_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cmd_o != 3'b111 && !is_dllrst) |-> (since_q >= 16'(T_DLL - 1)));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != 3'b111) |=> (cmd_o == 3'b111));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  assert_refresh_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cmd_o == 3'b001) |-> $past(done_o));

  assert_ready_only_ref_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd_o == 3'b111 || cmd_o == 3'b001));
endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(.AW(AW), .BAW(BAW), .T_DLL(T_DLL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cmd_o  (cmd_o),
  .bank_o (bank_o),
  .addr_o (addr_o),
  .done_o (done_o)
);

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;
  localparam int T_RP   = 3;
  localparam int T_MRD  = 2;
  localparam int T_RFC  = 8;
  localparam int T_DLL  = 200;
  localparam int T_REFI = 50;

  typedef struct {
    logic [2:0]  cmd;
    logic [1:0]  bank;
    logic [12:0] addr;
    int          cyc;
    string       tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [12:0] addr_o;
  logic        done_o;

  int        cyc = 0;
  int        n_tests = 0;
  int        n_fail = 0;
  int        done_cyc = 0;
  bit        mon_en = 1'b0;
  bit        finished = 1'b0;
  exp_item_t exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_pwrup_seq #(
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL), .T_REFI(T_REFI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .addr_o(addr_o), .done_o(done_o)
  );

  task automatic push(input logic [2:0] c, input logic [1:0] b,
                      input logic [12:0] a, input int at, input string tag);
    exp_item_t it;
    it.cmd = c; it.bank = b; it.addr = a; it.cyc = at; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Driver: pulse start and push the full expected schedule
  task automatic run_seq(input int n_ref);
    int s;
    int t;
    @(negedge clk);
    start_i = 1'b1;
    s = cyc;
    t = s + 1;
    push(3'b010, 2'd0, 13'h400, t, "R2");
    t += T_RP;  push(3'b000, 2'd1, 13'h000, t, "R3");
    t += T_MRD; push(3'b000, 2'd0, 13'h163, t, "R4");
    t += T_DLL; push(3'b010, 2'd0, 13'h400, t, "R5");
    t += T_RP;  push(3'b001, 2'd0, 13'h000, t, "R6");
    t += T_RFC; push(3'b001, 2'd0, 13'h000, t, "R6");
    t += T_RFC; push(3'b000, 2'd0, 13'h063, t, "R7");
    t += T_MRD;
    done_cyc = t;
    for (int k = 1; k <= n_ref; k++)
      push(3'b001, 2'd0, 13'h000, t + k * T_REFI - 1, "R10");
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pop and compare each command as it appears
  always @(negedge clk) begin
    if (mon_en) begin
      if (cmd_o != 3'b111) begin
        n_tests++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R8/R11: unexpected cmd %b addr %h at cycle %0d, expected none",
                   cmd_o, addr_o, cyc);
        end else begin
          exp_item_t it;
          it = exp_q.pop_front();
          if (cmd_o !== it.cmd || bank_o !== it.bank || addr_o !== it.addr || cyc != it.cyc) begin
            n_fail++;
            $display("FAIL %s: got cmd %b bank %0d addr %h cyc %0d, expected cmd %b bank %0d addr %h cyc %0d",
                     it.tag, cmd_o, bank_o, addr_o, cyc, it.cmd, it.bank, it.addr, it.cyc);
          end
        end
      end
      n_tests++;
      if (done_o !== (done_cyc != 0 && cyc >= done_cyc)) begin
        n_fail++;
        $display("FAIL R9: done %b at cycle %0d, expected %b (rise at %0d)",
                 done_o, cyc, (done_cyc != 0 && cyc >= done_cyc), done_cyc);
      end
    end
  end

  task automatic check_drained(input string tag);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d expected commands missing, expected 0", tag, exp_q.size());
    end
    exp_q.delete();
  endtask

  task automatic check_reset_outputs();
    n_tests++;
    if (cmd_o !== 3'b111 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: cmd %b done %b in reset, expected 111 0", cmd_o, done_o);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // Run 1
    wait_cycles(3);
    check_reset_outputs();            // R1
    @(negedge clk);
    rst_n = 1'b1;
    done_cyc = 0;
    mon_en = 1'b1;
    wait_cycles(12);                  // R1: idle, monitor flags any command
    fork
      run_seq(3);
      begin
        wait_cycles(60);
        pulse_start();                // R11: during DLL wait
        wait_cycles(150);
        pulse_start();                // R11: later in the sequence
      end
    join
    wait (done_o === 1'b1);
    wait_cycles(10);
    pulse_start();                    // R11: after done
    wait_cycles(3 * T_REFI + 5);
    check_drained("R10");
    // Run 2: reset mid-ready, different start offset
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    wait_cycles(2);
    check_reset_outputs();            // R1
    done_cyc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    wait_cycles(7);
    run_seq(2);
    wait (done_o === 1'b1);
    wait_cycles(2 * T_REFI + 5);
    check_drained("R9");
    finish_run();
  end
endmodule